// File: doc/BRIEF.md
# Page-Mode DRAM Cycle Decoder with Output Control

This block is the device-side control front end of an asynchronous page-mode dynamic memory organised as one million bytes. It watches the four active-low strobes (row strobe, column strobe, write enable and output enable) on a fast system clock. The strobes reach it already synchronised. From the order in which the strobes fall, it decides what kind of cycle is running. It then keeps an output data latch, drives an enable for the eight data pins, and steps an internal ten-bit refresh row counter whenever a column-before-row refresh cycle completes.

The row and column addresses share one multiplexed address input. The row is captured when the row strobe falls and the column when the column strobe falls. The storage behind the block is a small behavioural stub. It is indexed by the low bits of the row and the column, which is enough to show that data takes the right path. The block reports the decoded cycle kind and the active row, so that a surrounding environment can follow what it is doing.

Top module: `fpm_cycle_ctrl`

## Requirements
- R1: After reset, cycleType is 0 (idle), dqOe is 0, dqOut is 0, refreshRow is 0 and activeRow is 0.
- R2: When the row strobe falls with the column strobe high, and the column strobe then falls with write enable high, cycleType becomes 1 (read) one clock later. dqOut then holds the byte stored at stub index {row[1:0], column[1:0]}, and dqOe equals (oeN low and weN high).
- R3: Taking oeN high sets dqOe to 0 and leaves dqOut unchanged. Taking it low again restores dqOe.
- R4: When write enable is low as the column strobe falls, cycleType becomes 2 (early write). dIn is stored at the addressed index, and dqOe stays 0.
- R5: When write enable falls during a read cycle while oeN is high, cycleType becomes 3 (late write). dIn is stored at the column captured at the column strobe fall, and dqOut keeps the byte read earlier.
- R6: When write enable falls during a read cycle while oeN is low, cycleType becomes 4 (read-modify-write), and dIn is stored at the captured column. dqOe is 0 while write enable is low.
- R7: While the row strobe stays low, each new fall of the column strobe reclassifies the cycle and reads a new column of the same row.
- R8: A row strobe fall with the column strobe high gives cycleType 5 (row-only refresh), sets activeRow to the address input and keeps dqOe at 0.
- R9: A column strobe fall while the row strobe is high gives cycleType 7 (column-only) with dqOe 0.
- R10: The row strobe falling while the column strobe is low, after a column strobe fall that happened with the row strobe high since the last row strobe fall, gives cycleType 6 (column-before-row refresh). activeRow takes the refresh counter value and ignores the address input, and dqOut does not change.
- R11: refreshRow increments by one when a column-before-row cycle ends, and wraps from 1023 to 0.
- R12: When both the row and column strobes are high after a cycle, cycleType returns to 0. The output latch is cleared (dqOut 0, dqOe 0), except at the end of a column-before-row refresh, which leaves the latch as it was.
- R13: The row strobe falling while the column strobe is low, with no column strobe fall since the previous row strobe fall, gives cycleType 5, and the latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low, synchronised |
| casN | input | 1 | Column strobe, active low, synchronised |
| weN | input | 1 | Write enable, active low, synchronised |
| oeN | input | 1 | Output enable, active low, synchronised |
| addr | input | 10 | Multiplexed row/column address |
| dIn | input | 8 | Write data from the pins |
| dqOut | output | 8 | Output data latch contents |
| dqOe | output | 1 | Drive enable for the data pins |
| cycleType | output | 3 | Decoded cycle code (0 idle, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only, 6 column-before-row, 7 column-only) |
| activeRow | output | 10 | Row captured for the current cycle |
| refreshRow | output | 10 | Internal refresh row counter |

## Verification
The assertions rely on the strobes changing one at a time, with at least one clock between two strobe edges. A row and column strobe fall in the same sample would be read as a row-only start. The stimulus therefore moves a single strobe per step and holds it for two clocks. The address and write data are set up before the strobe edge that captures them. A behavioural model in the bench tracks the cycle code, the latch, the stub contents and the counter, and is compared with the outputs after every edge.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE      = 3'd0,
    CYC_READ      = 3'd1,
    CYC_EARLY_WR  = 3'd2,
    CYC_LATE_WR   = 3'd3,
    CYC_RMW       = 3'd4,
    CYC_ROW_ONLY  = 3'd5,
    CYC_CBR       = 3'd6,
    CYC_COL_ONLY  = 3'd7
  } cyc_e;

  typedef struct packed {
    logic rowLoad;     // capture a row at the start of a cycle
    logic rowFromCnt;  // take the row from the refresh counter
    logic colLoad;     // capture the column from the address input
    logic latchLoad;   // fill the output latch from the stub
    logic latchClear;  // empty the output latch
    logic wrEn;        // store write data into the stub
    logic cntInc;      // advance the refresh counter
  } strobes_t;

endpackage

// File: rtl/fpm_refresh_ctr.sv
module fpm_refresh_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [ROW_W-1:0] count
);
  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (inc) begin
      count <= count + ONE;  // natural wrap at 2**ROW_W
    end
  end
endmodule

// File: rtl/fpm_array_stub.sv
module fpm_array_stub #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= '0;
      end
    end else if (wrEn) begin
      cells[wrIdx] <= wrData;
    end
  end

  assign rdData = cells[rdIdx];
endmodule

// File: rtl/fpm_cycle_ctl.sv
module fpm_cycle_ctl
  import fpm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rasN,
  input  logic     casN,
  input  logic     weN,
  input  logic     oeN,
  output cyc_e     cycleType,
  output strobes_t stb
);
  logic rasQ, casQ, weQ;
  logic armed, nextArmed;
  cyc_e typeQ, nextType;
  logic rasFall, casFall, weFall;
  logic accessOpen;

  assign rasFall = rasQ & ~rasN;
  assign casFall = casQ & ~casN;
  assign weFall  = weQ & ~weN;

  // A column strobe fall starts a data access only inside a row cycle
  // that is not a refresh-only cycle.
  assign accessOpen = (typeQ != CYC_IDLE) && (typeQ != CYC_CBR) &&
                      (typeQ != CYC_COL_ONLY);

  always_comb begin
    nextType  = typeQ;
    nextArmed = armed;
    stb       = '0;
    if (rasFall) begin
      nextArmed   = 1'b0;
      stb.rowLoad = 1'b1;
      if (!casN && armed) begin
        nextType       = CYC_CBR;
        stb.rowFromCnt = 1'b1;
      end else begin
        nextType       = CYC_ROW_ONLY;
        stb.latchClear = 1'b1;
      end
    end else if (casFall) begin
      if (rasN) begin
        nextType  = CYC_COL_ONLY;
        nextArmed = 1'b1;
      end else if (accessOpen) begin
        stb.colLoad = 1'b1;
        if (!weN) begin
          nextType       = CYC_EARLY_WR;
          stb.wrEn       = 1'b1;
          stb.latchClear = 1'b1;
        end else begin
          nextType      = CYC_READ;
          stb.latchLoad = 1'b1;
        end
      end
    end else if (weFall && !casN && !rasN && typeQ == CYC_READ) begin
      nextType = oeN ? CYC_LATE_WR : CYC_RMW;
      stb.wrEn = 1'b1;
    end else if (rasN && casN && typeQ != CYC_IDLE) begin
      if (typeQ == CYC_CBR) begin
        stb.cntInc = 1'b1;
      end else begin
        stb.latchClear = 1'b1;
      end
      nextType = CYC_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasQ  <= 1'b1;
      casQ  <= 1'b1;
      weQ   <= 1'b1;
      armed <= 1'b0;
      typeQ <= CYC_IDLE;
    end else begin
      rasQ  <= rasN;
      casQ  <= casN;
      weQ   <= weN;
      armed <= nextArmed;
      typeQ <= nextType;
    end
  end

  assign cycleType = typeQ;
endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int STUB_R_W = 2,
  parameter int STUB_C_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  input  logic              weN,
  input  logic              oeN,
  input  strobes_t          stb,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [ADDR_W-1:0] activeRow,
  output logic [ADDR_W-1:0] refreshRow
);
  localparam int IDX_W = STUB_R_W + STUB_C_W;

  logic [ADDR_W-1:0] rowQ, colQ, colSel;
  logic [DATA_W-1:0] latchData, rdData;
  logic              latchValid;
  logic [IDX_W-1:0]  rdIdx, wrIdx;

  fpm_refresh_ctr #(.ROW_W(ADDR_W)) u_ctr (
    .clk   (clk),
    .rstN  (rstN),
    .inc   (stb.cntInc),
    .count (refreshRow)
  );

  assign colSel = stb.colLoad ? addr : colQ;
  assign rdIdx  = {rowQ[STUB_R_W-1:0], addr[STUB_C_W-1:0]};
  assign wrIdx  = {rowQ[STUB_R_W-1:0], colSel[STUB_C_W-1:0]};

  fpm_array_stub #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_stub (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (stb.wrEn),
    .wrIdx  (wrIdx),
    .wrData (dIn),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else begin
      if (stb.rowLoad) begin
        rowQ <= stb.rowFromCnt ? refreshRow : addr;
      end
      if (stb.colLoad) begin
        colQ <= addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchValid <= 1'b0;
      latchData  <= '0;
    end else if (stb.latchClear) begin
      latchValid <= 1'b0;
      latchData  <= '0;
    end else if (stb.latchLoad) begin
      latchValid <= 1'b1;
      latchData  <= rdData;
    end
  end

  assign dqOut     = latchData;
  assign dqOe      = latchValid & ~oeN & weN;
  assign activeRow = rowQ;
endmodule

// File: rtl/fpm_cycle_ctrl.sv
module fpm_cycle_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int STUB_R_W = 2,
  parameter int STUB_C_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [2:0]        cycleType,
  output logic [ADDR_W-1:0] activeRow,
  output logic [ADDR_W-1:0] refreshRow
);
  strobes_t stb;
  cyc_e     typeNow;

  fpm_cycle_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .oeN       (oeN),
    .cycleType (typeNow),
    .stb       (stb)
  );

  fpm_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STUB_R_W (STUB_R_W),
    .STUB_C_W (STUB_C_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .dIn        (dIn),
    .weN        (weN),
    .oeN        (oeN),
    .stb        (stb),
    .dqOut      (dqOut),
    .dqOe       (dqOe),
    .activeRow  (activeRow),
    .refreshRow (refreshRow)
  );

  assign cycleType = typeNow;
endmodule

// File: rtl/fpm_cycle_chk.sv
module fpm_cycle_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cycleType,
  input logic              dqOe,
  input logic [DATA_W-1:0] dqOut,
  input logic [ADDR_W-1:0] refreshRow
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  AST_EARLY_WRITE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    cycleType == 3'd2 |-> !dqOe); // R4

  AST_ROW_ONLY_DARK: assert property (@(posedge clk) disable iff (!rstN)
    cycleType == 3'd5 |-> !dqOe); // R8

  AST_COL_ONLY_DARK: assert property (@(posedge clk) disable iff (!rstN)
    cycleType == 3'd7 |-> !dqOe); // R9

  AST_CBR_LATCH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cycleType == 3'd6 |=> $stable(dqOut)); // R10

  AST_COUNTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    refreshRow != $past(refreshRow) |-> refreshRow == $past(refreshRow) + STEP); // R11

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    cycleType == 3'd0 |-> !dqOe); // R12
endmodule

bind fpm_cycle_ctrl fpm_cycle_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cycleType  (cycleType),
  .dqOe       (dqOe),
  .dqOut      (dqOut),
  .refreshRow (refreshRow)
);

// File: tb/fpm_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_cycle_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] dIn = '0;
  logic [7:0] dqOut;
  logic       dqOe;
  logic [2:0] cycleType;
  logic [9:0] activeRow, refreshRow;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fpm_cycle_ctrl u_fpm_cycle_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dqOut(dqOut), .dqOe(dqOe), .cycleType(cycleType),
    .activeRow(activeRow), .refreshRow(refreshRow)
  );

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int mType, mArmed, mRow, mCol, mCnt, mValid, mData;
  int mem [16];
  bit pRas, pCas, pWe;

  function automatic string tagOf(int t);
    case (t)
      0: return "R12";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R8";
      6: return "R10";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    bit sRas, sCas, sWe, sOe, sRst;
    int sAddr, sDin, at;
    sRas = rasN; sCas = casN; sWe = weN; sOe = oeN; sRst = rstN;
    sAddr = addr; sDin = dIn;
    #1;
    if (!sRst) begin
      mType = 0; mArmed = 0; mRow = 0; mCol = 0; mCnt = 0; mValid = 0; mData = 0;
      foreach (mem[i]) mem[i] = 0;
      pRas = 1; pCas = 1; pWe = 1;
    end else begin
      if (pRas && !sRas) begin
        if (!sCas && mArmed != 0) begin
          mType = 6; mRow = mCnt;
        end else begin
          mType = 5; mRow = sAddr; mValid = 0; mData = 0;
        end
        mArmed = 0;
      end else if (pCas && !sCas) begin
        if (sRas) begin
          mType = 7; mArmed = 1;
        end else if (mType >= 1 && mType <= 5) begin
          mCol = sAddr;
          at = (mRow % 4) * 4 + (mCol % 4);
          if (!sWe) begin
            mem[at] = sDin; mType = 2; mValid = 0; mData = 0;
          end else begin
            mType = 1; mValid = 1; mData = mem[at];
          end
        end
      end else if (pWe && !sWe && !sCas && !sRas && mType == 1) begin
        mType = sOe ? 3 : 4;
        mem[(mRow % 4) * 4 + (mCol % 4)] = sDin;
      end else if (sRas && sCas && mType != 0) begin
        if (mType == 6) mCnt = (mCnt + 1) % 1024;
        else begin mValid = 0; mData = 0; end
        mType = 0;
      end
      pRas = sRas; pCas = sCas; pWe = sWe;
      chk({tagOf(mType), " cycle code"}, cycleType, mType);
      chk({tagOf(mType), " data latch"}, dqOut, mData);
      chk({tagOf(mType), " drive enable"}, dqOe, (mValid != 0 && !oeN && weN) ? 1 : 0);
      chk("R11 refresh counter", refreshRow, mCnt);
      chk("R8 active row", activeRow, mRow);
    end
  end

  // ---------------- stimulus ----------------
  task automatic settle();
    repeat (2) @(negedge clk);
  endtask
  task automatic rasDown(int row); addr = 10'(row); settle(); rasN = 0; settle(); endtask
  task automatic rasUp(); rasN = 1; settle(); endtask
  task automatic casDown(int col); addr = 10'(col); settle(); casN = 0; settle(); endtask
  task automatic casUp(); casN = 1; settle(); endtask
  task automatic weDown(int d); dIn = 8'(d); settle(); weN = 0; settle(); endtask
  task automatic weUp(); weN = 1; settle(); endtask
  task automatic oeSet(bit v); oeN = v; settle(); endtask

  task automatic cbrCycle();
    casDown(0); rasDown(777); casUp(); rasUp();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset cycle", cycleType, 0);
    chk("R1 reset enable", dqOe, 0);
    chk("R1 reset data", dqOut, 0);
    chk("R1 reset counter", refreshRow, 0);
    chk("R1 reset row", activeRow, 0);

    // early writes into row 5, columns 2 and 3
    rasDown(5); weDown(8'hA5); casDown(2);
    chk("R4 early write code", cycleType, 2);
    chk("R4 early write dark", dqOe, 0);
    weUp();
    chk("R4 dark after WE high", dqOe, 0);
    casUp(); weDown(8'h3C); casDown(3); casUp(); weUp(); rasUp();
    chk("R12 idle code", cycleType, 0);

    // read with OE gating
    rasDown(5);
    chk("R8 row-only code", cycleType, 5);
    chk("R8 row captured", activeRow, 5);
    oeSet(0);
    chk("R8 dark before CAS", dqOe, 0);
    casDown(2);
    chk("R2 read code", cycleType, 1);
    chk("R2 read data", dqOut, 8'hA5);
    chk("R2 read drives", dqOe, 1);
    oeSet(1);
    chk("R3 OE high dark", dqOe, 0);
    chk("R3 latch kept", dqOut, 8'hA5);
    oeSet(0);
    chk("R3 OE low drives again", dqOe, 1);

    // page mode to next column, then read-modify-write
    casUp(); casDown(3);
    chk("R7 page read data", dqOut, 8'h3C);
    chk("R7 page read code", cycleType, 1);
    weDown(8'h77);
    chk("R6 rmw code", cycleType, 4);
    chk("R6 dark while WE low", dqOe, 0);
    weUp(); casUp(); rasUp();
    chk("R12 latch cleared", dqOut, 0);
    chk("R12 enable off", dqOe, 0);

    // late write with OE high
    oeSet(1);
    rasDown(5); casDown(2); weDown(8'h5A);
    chk("R5 late write code", cycleType, 3);
    chk("R5 dark", dqOe, 0);
    weUp(); oeSet(0);
    chk("R5 latch keeps read byte", dqOut, 8'hA5);
    casUp(); rasUp();

    // read back both writes
    rasDown(5); casDown(2);
    chk("R5 late write stored", dqOut, 8'h5A);
    casUp(); casDown(3);
    chk("R6 rmw stored", dqOut, 8'h77);
    casUp(); rasUp();

    // column-only then column-before-row refresh
    casDown(1);
    chk("R9 column-only code", cycleType, 7);
    chk("R9 dark", dqOe, 0);
    rasDown(999);
    chk("R10 refresh code", cycleType, 6);
    chk("R10 row from counter", activeRow, 0);
    chk("R10 latch unchanged", dqOut, 0);
    chk("R10 dark", dqOe, 0);
    casUp(); rasUp();
    chk("R11 counter stepped", refreshRow, 1);

    // column held low across a new row fall: not a refresh
    rasDown(6); casDown(0);
    chk("R13 read before", dqOe, 1);
    rasUp(); rasDown(6);
    chk("R13 row-only code", cycleType, 5);
    chk("R13 latch cleared", dqOe, 0);
    casUp(); rasUp();

    // counter wrap
    for (int i = 0; i < 1022; i++) cbrCycle();
    chk("R11 counter at top", refreshRow, 1023);
    cbrCycle();
    chk("R11 counter wrapped", refreshRow, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule